// File: doc/BRIEF.md
# Pipelined Hyperbolic CORDIC Exponential Unit

This block computes e^x in fixed point for a signed input anywhere in [-6, 6]. A three-register reduction front end splits the input into x = q·ln2 + r with |r| close to ln2/2 or less. The residue r goes through fifteen registered hyperbolic micro-rotations that need only shifts and adds. The integer q travels alongside r, and a final register scales e^r by 2^q. The reduction and reconstruction path holds the block's only two multipliers: one forms q = round(x/ln2) and the other forms q·ln2.

The datapath is fully pipelined. Each clock a new sample may be offered with `in_valid`, and its result appears with `out_valid` a fixed number of cycles later. There is no back-pressure. Inputs beyond the domain are clamped to the nearest end of it before reduction. The rotation pipeline starts with x at the inverse hyperbolic gain and y at zero, so the sum x + y at the end equals cosh(r) + sinh(r) = e^r.

Top module: `exp_cordic_top`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly 19 clock cycles (3 reduction, 15 rotation, 1 scaling). While `rst_n` is low, and after it has been low, every in-flight sample is discarded and `out_valid` stays 0 until a new sample has crossed the pipeline.
- R2: A sample is accepted on every clock edge with `in_valid` high, including long back-to-back bursts, and results leave in the order the samples entered.
- R3: `in_x` is a 20-bit two's-complement value with 16 fraction bits. `out_exp` is a 32-bit unsigned value with 22 fraction bits. For any input in [-6, 6], |out/2^22 − e^x| / e^x ≤ 1e-3, including inputs next to the points x = (k+0.5)·ln2 where the reduction changes its integer part.
- R4: An input above +6.0 gives a result within 1e-3 of e^6 (about 403.43). An input below −6.0 gives a result within 1e-3 of e^−6. This holds up to the extreme codes 0x7FFFF and 0x80000.
- R5: An input of exactly zero gives 1.0 within a relative error of 1e-3.
- R6: Gaps in `in_valid` reappear as gaps in `out_valid`. No result is produced for a cycle without an accepted sample, and no accepted sample is lost.
- R7: When `out_valid` is high, `out_exp` never exceeds 404.0 (404·2^22).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears all valid flags |
| in_valid | input | 1 | Qualifies `in_x` in this cycle |
| in_x | input | 20 | Signed input, 16 fraction bits |
| out_valid | output | 1 | Qualifies `out_exp` in this cycle |
| out_exp | output | 32 | Unsigned e^x, 22 fraction bits |

## Verification
The hardest case to reach is the edge of the reduction. There, x/ln2 lies halfway between two integers, the rounding of q flips, and the residue reaches its largest magnitude. The rotation stages then work nearest to their own limit, and the final scaling shift changes by one place. A plain sweep rarely lands on these points. The stimulus therefore computes each crossing x = (k+0.5)·ln2 for every k that fits the domain and drives the code on the crossing and the codes one step to either side. This is mixed with saturated extremes, a long burst and irregular gaps, so that the reconstruction alignment of q is stressed at full rate.

// File: rtl/exp_cordic_pkg.sv
package exp_cordic_pkg;

    // number formats
    localparam int IN_W     = 20;   // signed input width
    localparam int IN_FRAC  = 16;   // input fraction bits
    localparam int CW       = 28;   // rotation datapath width
    localparam int CF       = 24;   // rotation datapath fraction bits
    localparam int OUT_W    = 32;   // unsigned output width
    localparam int OUT_FRAC = 22;   // output fraction bits
    localparam int Q_W      = 5;    // signed width of the ln2 multiple

    // domain and structure
    localparam int X_MAX_INT = 6;   // clamp magnitude, integer units
    localparam int N_STAGES  = 15;  // micro-rotations, repeats included
    localparam int RR_LAT    = 3;   // reduction registers
    localparam int TOTAL_LAT = RR_LAT + N_STAGES + 1;

    // stage positions (0-based) that re-run the previous shift
    localparam int REP_POS_A = 4;
    localparam int REP_POS_B = 14;

    // shift amount of rotation stage k: 1,2,3,4,4,5,...,13,13
    function automatic int stage_shift(input int k);
        int s;
        s = k + 1;
        if (k >= REP_POS_A) s = s - 1;
        if (k >= REP_POS_B) s = s - 1;
        return s;
    endfunction

    // 2^-idx as a real
    function automatic real pow2_neg(input int idx);
        real t;
        t = 1.0;
        for (int n = 0; n < idx; n++) t = t / 2.0;
        return t;
    endfunction

    // inverse hyperbolic tangent of 2^-idx
    function automatic real atanh_real(input int idx);
        real t;
        real acc;
        real pw;
        case (idx)
            1: return 0.5493061443340549;
            2: return 0.2554128118829953;
            3: return 0.1256572141404530;
            default: begin
                t   = pow2_neg(idx);
                acc = 0.0;
                pw  = t;
                for (int n = 1; n <= 9; n += 2) begin
                    acc = acc + pw / real'(n);
                    pw  = pw * t * t;
                end
                return acc;
            end
        endcase
    endfunction

    // scale factor 2^bits as a real
    function automatic real scale_of(input int bits);
        return real'(longint'(1) << bits);
    endfunction

endpackage

// File: rtl/exp_range_reduce.sv
module exp_range_reduce
    import exp_cordic_pkg::*;
#(
    parameter int P_IN_W    = IN_W,
    parameter int P_IN_FRAC = IN_FRAC,
    parameter int P_CW      = CW,
    parameter int P_CF      = CF,
    parameter int P_Q_W     = Q_W,
    parameter int P_X_MAX   = X_MAX_INT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [P_IN_W-1:0] in_x,
    output logic                     out_valid,
    output logic signed [P_CW-1:0]   out_r,
    output logic signed [P_Q_W-1:0]  out_q
);

    localparam int INV_W  = P_IN_FRAC + 2;
    localparam int PROD_W = P_IN_W + INV_W;
    localparam int QSH    = 2 * P_IN_FRAC;
    localparam int LN2_W  = P_CF + 1;
    localparam int XSH    = P_CF - P_IN_FRAC;

    localparam logic signed [INV_W-1:0] INV_LN2 =
        INV_W'(longint'(1.4426950408889634 * scale_of(P_IN_FRAC)));
    localparam logic signed [LN2_W-1:0] LN2_C =
        LN2_W'(longint'(0.6931471805599453 * scale_of(P_CF)));
    localparam logic signed [PROD_W-1:0] Q_RND =
        PROD_W'(longint'(1) << (QSH - 1));
    localparam logic signed [P_IN_W-1:0] LIM =
        P_IN_W'(longint'(P_X_MAX) << P_IN_FRAC);

    // stage 1: clamp
    logic signed [P_IN_W-1:0] x1;
    // stage 2: integer multiple of ln2
    logic signed [P_IN_W-1:0] x2;
    logic signed [P_Q_W-1:0]  q2;
    // stage 3: residue
    logic signed [P_CW-1:0]   r3;
    logic signed [P_Q_W-1:0]  q3;

    logic [RR_LAT-1:0] v_pipe;

    logic signed [PROD_W-1:0] prod_q;
    logic signed [P_CW-1:0]   prod_ln2;
    logic signed [P_CW-1:0]   x2_ext;

    assign prod_q   = PROD_W'(x1) * PROD_W'(INV_LN2);
    assign prod_ln2 = P_CW'(q2) * P_CW'(LN2_C);
    assign x2_ext   = P_CW'(x2) <<< XSH;

    always_ff @(posedge clk) begin
        if (in_x > LIM) begin
            x1 <= LIM;
        end else if (in_x < -LIM) begin
            x1 <= -LIM;
        end else begin
            x1 <= in_x;
        end
        x2 <= x1;
        q2 <= P_Q_W'((prod_q + Q_RND) >>> QSH);
        r3 <= x2_ext - prod_ln2;
        q3 <= q2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_pipe <= '0;
        end else begin
            v_pipe <= {v_pipe[RR_LAT-2:0], in_valid};
        end
    end

    assign out_valid = v_pipe[RR_LAT-1];
    assign out_r     = r3;
    assign out_q     = q3;

endmodule

// File: rtl/exp_hyp_stage.sv
module exp_hyp_stage #(
    parameter int                     P_CW    = 28,
    parameter int                     P_Q_W   = 5,
    parameter int                     P_SHIFT = 1,
    parameter logic signed [P_CW-1:0] P_ANGLE = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [P_CW-1:0]  in_x,
    input  logic signed [P_CW-1:0]  in_y,
    input  logic signed [P_CW-1:0]  in_z,
    input  logic signed [P_Q_W-1:0] in_q,
    output logic                    out_valid,
    output logic signed [P_CW-1:0]  out_x,
    output logic signed [P_CW-1:0]  out_y,
    output logic signed [P_CW-1:0]  out_z,
    output logic signed [P_Q_W-1:0] out_q
);

    logic signed [P_CW-1:0] y_sh;
    logic signed [P_CW-1:0] x_sh;
    logic                   rot_pos;

    assign y_sh    = in_y >>> P_SHIFT;
    assign x_sh    = in_x >>> P_SHIFT;
    assign rot_pos = ~in_z[P_CW-1];

    always_ff @(posedge clk) begin
        if (rot_pos) begin
            out_x <= in_x + y_sh;
            out_y <= in_y + x_sh;
            out_z <= in_z - P_ANGLE;
        end else begin
            out_x <= in_x - y_sh;
            out_y <= in_y - x_sh;
            out_z <= in_z + P_ANGLE;
        end
        out_q <= in_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

endmodule

// File: rtl/exp_out_scale.sv
module exp_out_scale #(
    parameter int P_CW       = 28,
    parameter int P_CF       = 24,
    parameter int P_Q_W      = 5,
    parameter int P_OUT_W    = 32,
    parameter int P_OUT_FRAC = 22
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [P_CW-1:0]  in_x,
    input  logic signed [P_CW-1:0]  in_y,
    input  logic signed [P_Q_W-1:0] in_q,
    output logic                    out_valid,
    output logic [P_OUT_W-1:0]      out_val
);

    localparam int BIAS = 1 << (P_Q_W - 1);
    localparam int TW   = P_CW + (1 << P_Q_W);
    localparam int DROP = P_CF + BIAS - P_OUT_FRAC;
    localparam logic [TW-1:0] RND = TW'(1) << (DROP - 1);

    logic signed [P_CW:0]  sum;
    logic [P_CW-1:0]       mant;
    logic [P_Q_W-1:0]      shamt;
    logic [TW-1:0]         shifted;
    logic [TW-1:0]         scaled;
    logic                  ovf;

    assign sum   = (P_CW+1)'(in_x) + (P_CW+1)'(in_y);
    assign mant  = sum[P_CW] ? '0 : sum[P_CW-1:0];
    // q + BIAS: flip the sign bit of the two's-complement q
    assign shamt = {~in_q[P_Q_W-1], in_q[P_Q_W-2:0]};

    always_comb begin
        shifted = (TW'(mant) << shamt) + RND;
        scaled  = shifted >> DROP;
        ovf     = |(scaled >> P_OUT_W);
    end

    always_ff @(posedge clk) begin
        out_val <= ovf ? '1 : P_OUT_W'(scaled);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

endmodule

// File: rtl/exp_cordic_top.sv
module exp_cordic_top
    import exp_cordic_pkg::*;
#(
    parameter int P_IN_W     = IN_W,
    parameter int P_IN_FRAC  = IN_FRAC,
    parameter int P_CW       = CW,
    parameter int P_CF       = CF,
    parameter int P_Q_W      = Q_W,
    parameter int P_OUT_W    = OUT_W,
    parameter int P_OUT_FRAC = OUT_FRAC,
    parameter int P_STAGES   = N_STAGES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [P_IN_W-1:0] in_x,
    output logic                     out_valid,
    output logic [P_OUT_W-1:0]       out_exp
);

    localparam logic signed [P_CW-1:0] INV_GAIN =
        P_CW'(longint'(1.2074970677630725 * scale_of(P_CF)));

    logic                    v_s [0:P_STAGES];
    logic signed [P_CW-1:0]  x_s [0:P_STAGES];
    logic signed [P_CW-1:0]  y_s [0:P_STAGES];
    logic signed [P_CW-1:0]  z_s [0:P_STAGES];
    logic signed [P_Q_W-1:0] q_s [0:P_STAGES];

    exp_range_reduce #(
        .P_IN_W    (P_IN_W),
        .P_IN_FRAC (P_IN_FRAC),
        .P_CW      (P_CW),
        .P_CF      (P_CF),
        .P_Q_W     (P_Q_W),
        .P_X_MAX   (X_MAX_INT)
    ) u_reduce (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_x      (in_x),
        .out_valid (v_s[0]),
        .out_r     (z_s[0]),
        .out_q     (q_s[0])
    );

    assign x_s[0] = INV_GAIN;
    assign y_s[0] = '0;

    for (genvar k = 0; k < P_STAGES; k++) begin : g_stage
        localparam int SH = stage_shift(k);
        localparam logic signed [P_CW-1:0] ANG =
            P_CW'(longint'(atanh_real(SH) * scale_of(P_CF)));

        exp_hyp_stage #(
            .P_CW    (P_CW),
            .P_Q_W   (P_Q_W),
            .P_SHIFT (SH),
            .P_ANGLE (ANG)
        ) u_rot (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (v_s[k]),
            .in_x      (x_s[k]),
            .in_y      (y_s[k]),
            .in_z      (z_s[k]),
            .in_q      (q_s[k]),
            .out_valid (v_s[k+1]),
            .out_x     (x_s[k+1]),
            .out_y     (y_s[k+1]),
            .out_z     (z_s[k+1]),
            .out_q     (q_s[k+1])
        );
    end

    exp_out_scale #(
        .P_CW       (P_CW),
        .P_CF       (P_CF),
        .P_Q_W      (P_Q_W),
        .P_OUT_W    (P_OUT_W),
        .P_OUT_FRAC (P_OUT_FRAC)
    ) u_scale (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (v_s[P_STAGES]),
        .in_x      (x_s[P_STAGES]),
        .in_y      (y_s[P_STAGES]),
        .in_q      (q_s[P_STAGES]),
        .out_valid (out_valid),
        .out_val   (out_exp)
    );

    // residual angle is not part of the result
    logic z_tail_unused;
    assign z_tail_unused = ^z_s[P_STAGES];

endmodule

// File: rtl/exp_cordic_chk.sv
module exp_cordic_chk
    import exp_cordic_pkg::*;
#(
    parameter int P_IN_W     = IN_W,
    parameter int P_IN_FRAC  = IN_FRAC,
    parameter int P_OUT_W    = OUT_W,
    parameter int P_OUT_FRAC = OUT_FRAC,
    parameter int P_LAT      = TOTAL_LAT
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic signed [P_IN_W-1:0] in_x,
    input logic                     out_valid,
    input logic [P_OUT_W-1:0]       out_exp
);

    localparam logic signed [P_IN_W-1:0] LIM =
        P_IN_W'(longint'(X_MAX_INT) << P_IN_FRAC);
    localparam longint ONE     = longint'(1) << P_OUT_FRAC;
    localparam longint ONE_TOL = ONE / 1000;
    localparam longint BOUND   = longint'(404) << P_OUT_FRAC;
    localparam longint HI_LO   = longint'(403.4287934927351 * scale_of(P_OUT_FRAC) * 0.999);
    localparam longint HI_HI   = longint'(403.4287934927351 * scale_of(P_OUT_FRAC) * 1.001);

    logic [P_LAT-1:0] v_dly;
    logic [P_LAT-1:0] zero_dly;
    logic [P_LAT-1:0] hi_dly;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_dly    <= '0;
            zero_dly <= '0;
            hi_dly   <= '0;
        end else begin
            v_dly    <= {v_dly[P_LAT-2:0], in_valid};
            zero_dly <= {zero_dly[P_LAT-2:0], in_valid && (in_x == '0)};
            hi_dly   <= {hi_dly[P_LAT-2:0], in_valid && (in_x > LIM)};
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v_dly[P_LAT-1]);                                          // R1

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !out_valid);                                                // R1

    AST_ZERO_GIVES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zero_dly[P_LAT-1]) |->
            (longint'(out_exp) >= ONE - ONE_TOL && longint'(out_exp) <= ONE + ONE_TOL)); // R5

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hi_dly[P_LAT-1]) |->
            (longint'(out_exp) >= HI_LO && longint'(out_exp) <= HI_HI));       // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> longint'(out_exp) <= BOUND);                             // R7

    AST_NONZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_exp != '0);                                          // R3

endmodule

bind exp_cordic_top exp_cordic_chk #(
    .P_IN_W     (P_IN_W),
    .P_IN_FRAC  (P_IN_FRAC),
    .P_OUT_W    (P_OUT_W),
    .P_OUT_FRAC (P_OUT_FRAC),
    .P_LAT      (exp_cordic_pkg::RR_LAT + P_STAGES + 1)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_x      (in_x),
    .out_valid (out_valid),
    .out_exp   (out_exp)
);

// File: tb/exp_cordic_top_tb.sv
module exp_cordic_top_tb;

    localparam int  CLK_PERIOD = 10;
    localparam int  EXP_LAT    = 19;
    localparam int  X_LIM      = 6 * 65536;
    localparam real OUT_SCALE  = 4194304.0;   // 2^22
    localparam real REL_TOL    = 1.0e-3;
    localparam longint OUT_MAX = longint'(404) * 4194304;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [19:0] in_x = '0;
    logic               out_valid;
    logic [31:0]        out_exp;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    real   exp_q [$];
    int    cyc_q [$];
    string tag_q [$];

    exp_cordic_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_x      (in_x),
        .out_valid (out_valid),
        .out_exp   (out_exp)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic real ref_exp(input int xv);
        int c;
        c = xv;
        if (c > X_LIM)  c = X_LIM;
        if (c < -X_LIM) c = -X_LIM;
        return $exp(real'(c) / 65536.0);
    endfunction

    task automatic check_bit(input string req, input logic act, input logic expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s: out_valid actual %0b expected %0b at cycle %0d", req, act, expv, cyc);
        end
    endtask

    task automatic send(input int xv, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_x     = 20'(xv);
        exp_q.push_back(ref_exp(xv));
        cyc_q.push_back(cyc);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_errors++;
                $display("FAIL R6: out_valid actual 1 expected 0 (no sample pending) at cycle %0d", cyc);
            end else begin
                real   e;
                real   a;
                real   rel;
                int    c0;
                string tg;
                e  = exp_q.pop_front();
                c0 = cyc_q.pop_front();
                tg = tag_q.pop_front();
                a  = real'(out_exp) / OUT_SCALE;
                rel = (a > e) ? (a - e) / e : (e - a) / e;
                n_checks++;
                if (rel > REL_TOL) begin
                    n_errors++;
                    $display("FAIL %s: out_exp actual %f expected %f (rel %e)", tg, a, e, rel);
                end
                n_checks++;
                if (cyc - c0 != EXP_LAT) begin
                    n_errors++;
                    $display("FAIL R1: latency actual %0d expected %0d", cyc - c0, EXP_LAT);
                end
                n_checks++;
                if (longint'(out_exp) > OUT_MAX) begin   // R7
                    n_errors++;
                    $display("FAIL R7: out_exp actual %0d expected <= %0d", out_exp, OUT_MAX);
                end
            end
        end
    end

    initial begin
        #(longint'(CLK_PERIOD) * 200000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: run actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check_bit("R1", out_valid, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            check_bit("R1", out_valid, 1'b0);
        end

        // R5: zero input
        send(0, "R5");
        idle(1);

        // R3: sweep across the domain including both ends
        for (int i = -120; i <= 120; i++) send(i * 3276, "R3");
        send(X_LIM, "R3");
        send(-X_LIM, "R3");
        idle(5);

        // R3: reduction crossings x = (k+0.5)*ln2 and neighbours
        for (int k = -9; k <= 8; k++) begin
            int xb;
            xb = int'((real'(k) + 0.5) * 0.6931471805599453 * 65536.0);
            if (xb < X_LIM && xb > -X_LIM) begin
                send(xb - 1, "R3");
                send(xb, "R3");
                send(xb + 1, "R3");
            end
        end
        idle(3);

        // R4: saturation, including extreme codes
        send(X_LIM + 1, "R4");
        send(491520, "R4");
        send(524287, "R4");
        send(-X_LIM - 1, "R4");
        send(-524288, "R4");
        send(-491520, "R4");
        idle(2);

        // R2: long back-to-back burst of mixed values
        for (int i = 0; i < 60; i++) send(((i * 7919) % 786433) - X_LIM, "R2");

        // R6: irregular gaps between samples
        for (int i = 0; i < 40; i++) begin
            send(((i * 104729) % 786433) - X_LIM, "R6");
            idle(i % 4);
        end
        idle(EXP_LAT + 10);

        // R2: every accepted sample produced a result
        n_checks++;
        if (exp_q.size() != 0) begin
            n_errors++;
            $display("FAIL R2: pending results actual %0d expected 0", exp_q.size());
        end

        // R1: reset while samples are in flight
        for (int i = 0; i < 6; i++) send(i * 20000, "R1");
        idle(3);
        @(negedge clk);
        rst_n = 1'b0;
        exp_q.delete();
        cyc_q.delete();
        tag_q.delete();
        repeat (2) @(negedge clk);
        check_bit("R1", out_valid, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < EXP_LAT + 6; i++) begin
            @(negedge clk);
            check_bit("R1", out_valid, 1'b0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule